// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Events and Interrupt Unit

This block sits between a simple register bus and a serial bus engine. It holds a transmit byte FIFO, filled by register writes and drained by the engine, and a receive byte FIFO, filled by the engine and drained by register reads. Each FIFO has a programmable level threshold. The threshold drives a "low water" event on the transmit side and a "high water" event on the receive side. Either FIFO can be emptied by a flush request that runs for a fixed number of cycles and then clears its own request bit.

An interrupt unit combines two kinds of source into one raw status word. Level sources follow the FIFO state. Latched sources are set by single-cycle pulses from the engine, or by a transmit overrun, and are cleared by writing ones to a clear register. A mask register selects which raw bits reach the masked status word. The single interrupt output is the OR of the masked status bits.

Top module: `txrx_fifo_irq`

## Requirements
- R1: After reset both FIFOs are empty, the mask, both thresholds and all latched events are zero, the raw status reads 0x00000033, and irq is 0.
- R2: Register word addresses on reg_addr are: 0 control, 1 transmit data (write), 2 receive data (read), 3 transmit threshold, 4 receive threshold, 5 mask, 6 raw status, 7 masked status, 8 clear (write-one-to-clear). Reads are combinational on reg_addr. Unlisted addresses read 0.
- R3: The transmit FIFO holds DEPTH (16) bytes. The engine sees them in write order on eng_tx_data while eng_tx_valid is 1, and eng_tx_pop advances to the next byte.
- R4: The receive FIFO holds DEPTH bytes pushed by the engine while eng_rx_ready is 1 (pushes to a full FIFO are dropped). Reading address 2 returns and removes them in push order. A read of an empty receive FIFO returns 0 and removes nothing.
- R5: The raw status level bits are: bit 0 transmit empty, bit 2 transmit full, bit 4 receive empty, bit 6 receive full.
- R6: Raw bit 1 (transmit nearly empty) is 1 while the transmit count is no greater than the transmit threshold. Threshold registers keep only the low 4 bits written, giving values 0 to 15.
- R7: Raw bit 5 (receive nearly full) is 1 while the receive count is at least the receive threshold.
- R8: A write to address 1 while the transmit FIFO is full drops the byte and latches raw bit 3 (overrun).
- R9: Input pulses latch raw bits: done with stop 19, done without stop 28, arbitration lost 24, bus error 25, evt_slave[0..3] at 16, 17, 18 and 20.
- R10: Writing ones to address 8 clears the latched bits under 0x131F007F. Level bits are not affected. A pulse in the same cycle as its clear leaves the bit set.
- R11: The mask register reads back bits 31:29 as zero. The masked status equals raw status AND mask, and irq is 1 exactly when the masked status is nonzero.
- R12: Writing control bit 0 (transmit) or bit 1 (receive) starts a flush. The bit reads 1 for FLUSH_CYCLES (4) cycles after the write, then reads 0, and the FIFO is then empty.
- R13: While a FIFO is flushing, register writes and reads of its data and engine pushes or pops to it are ignored, and a receive data read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 2) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_data | output | 8 | Head transmit byte |
| eng_tx_valid | output | 1 | Transmit byte available |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Receive FIFO can accept a byte |
| evt_done_stop | input | 1 | Pulse: transfer finished with stop |
| evt_done_nostop | input | 1 | Pulse: transfer finished without stop |
| evt_arb_lost | input | 1 | Pulse: arbitration lost |
| evt_bus_err | input | 1 | Pulse: bus error |
| evt_slave | input | 4 | Pulses: target-side events |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is at a known value once reset is released. They also assume one register access at a time, with the write and read strobes never high together. An engine pop or push may coincide with a register access, and the properties allow for this by naming every condition they depend on, such as an event pulse that lands in the same cycle as a clear. The stimulus changes all inputs only at the falling clock edge and holds each strobe for exactly one cycle. The overrun and flush properties are exercised by filling the transmit FIFO to its limit under several thresholds and by flushing while bytes are present.

// File: rtl/tfq_pkg.sv
package tfq_pkg;

   typedef enum logic [3:0] {
      REG_CTRL   = 4'd0,
      REG_TXDATA = 4'd1,
      REG_RXDATA = 4'd2,
      REG_TXTHR  = 4'd3,
      REG_RXTHR  = 4'd4,
      REG_MASK   = 4'd5,
      REG_RAW    = 4'd6,
      REG_MASKED = 4'd7,
      REG_CLEAR  = 4'd8
   } reg_sel_e;

   // status bit positions
   localparam int B_TX_EMPTY  = 0;
   localparam int B_TX_NEMPTY = 1;
   localparam int B_TX_FULL   = 2;
   localparam int B_TX_OVR    = 3;
   localparam int B_RX_EMPTY  = 4;
   localparam int B_RX_NFULL  = 5;
   localparam int B_RX_FULL   = 6;
   localparam int B_SLV0      = 16;
   localparam int B_SLV1      = 17;
   localparam int B_SLV2      = 18;
   localparam int B_DONE_STOP = 19;
   localparam int B_SLV3      = 20;
   localparam int B_ARB_LOST  = 24;
   localparam int B_BUS_ERR   = 25;
   localparam int B_DONE_NOST = 28;

   localparam logic [31:0] LEVEL_BITS    = 32'h0000_0077;
   localparam logic [31:0] LATCH_BITS    = 32'h131F_0008;
   localparam logic [31:0] CLEARABLE     = 32'h131F_007F;
   localparam logic [31:0] MASK_WRITABLE = 32'h1FFF_FFFF;

endpackage

// File: rtl/tfq_fifo.sv
module tfq_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear,
   input  logic                          push,
   input  logic [DW-1:0]                 din,
   input  logic                          pop,
   output logic [DW-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]    count,
   output logic                          empty,
   output logic                          full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("tfq_fifo: DEPTH must be a power of two, at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("tfq_fifo: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count_n;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = empty ? '0 : mem[rptr];

   always_comb begin
      case ({do_push, do_pop})
         2'b10:   count_n = count + 1'b1;
         2'b01:   count_n = count - 1'b1;
         default: count_n = count;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (clear) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         count <= count_n;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clear) mem[wptr] <= din;
   end

endmodule

// File: rtl/tfq_flush_seq.sv
module tfq_flush_seq #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYCLES+1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("tfq_flush_seq: CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
      else if (start)      cnt <= CW'(CYCLES);
   end

endmodule

// File: rtl/tfq_irq_unit.sv
module tfq_irq_unit
   import tfq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] level,
   input  logic [31:0] evt,
   input  logic        mask_we,
   input  logic        clr_we,
   input  logic [31:0] wdata,
   output logic [31:0] raw,
   output logic [31:0] masked,
   output logic [31:0] mask_q,
   output logic        irq
);
   logic [31:0] lat_q;
   logic [31:0] clr_vec;

   assign clr_vec = clr_we ? (wdata & CLEARABLE) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q  <= '0;
         mask_q <= '0;
      end else begin
         lat_q <= ((lat_q & ~clr_vec) | evt) & LATCH_BITS;
         if (mask_we) mask_q <= wdata & MASK_WRITABLE;
      end
   end

   assign raw    = lat_q | (level & LEVEL_BITS);
   assign masked = raw & mask_q;
   assign irq    = |masked;

endmodule

// File: rtl/txrx_fifo_irq.sv
module txrx_fifo_irq
   import tfq_pkg::*;
#(
   parameter int DW           = 8,
   parameter int DEPTH        = 16,
   parameter int FLUSH_CYCLES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [3:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          eng_tx_pop,
   output logic [DW-1:0] eng_tx_data,
   output logic          eng_tx_valid,
   input  logic          eng_rx_push,
   input  logic [DW-1:0] eng_rx_data,
   output logic          eng_rx_ready,
   input  logic          evt_done_stop,
   input  logic          evt_done_nostop,
   input  logic          evt_arb_lost,
   input  logic          evt_bus_err,
   input  logic [3:0]    evt_slave,
   output logic          irq
);
   localparam int THR_W = $clog2(DEPTH);
   localparam int CW    = $clog2(DEPTH+1);

   generate
      if (DW > 32) begin : g_bad_dw
         $error("txrx_fifo_irq: DW must fit the 32-bit register bus");
      end
   endgenerate

   logic [THR_W-1:0] tx_thr, rx_thr;
   logic             tx_busy, rx_busy, tx_done, rx_done;
   logic [CW-1:0]    tx_count, rx_count;
   logic             tx_empty, tx_full, rx_empty, rx_full;
   logic [DW-1:0]    rx_dout;
   logic             tx_push, tx_pop, rx_push, rx_pop, tx_ovr;
   logic             wr_ctrl;
   logic [31:0]      level_vec, evt_vec, raw_status, masked_status, mask_q;

   assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
   assign tx_push = reg_wr && (reg_addr == REG_TXDATA) && !tx_busy;
   assign tx_ovr  = tx_push && tx_full;
   assign tx_pop  = eng_tx_pop && !tx_busy;
   assign rx_push = eng_rx_push && !rx_busy;
   assign rx_pop  = reg_rd && (reg_addr == REG_RXDATA) && !rx_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_thr <= '0;
         rx_thr <= '0;
      end else if (reg_wr) begin
         if (reg_addr == REG_TXTHR) tx_thr <= reg_wdata[THR_W-1:0];
         if (reg_addr == REG_RXTHR) rx_thr <= reg_wdata[THR_W-1:0];
      end
   end

   tfq_flush_seq #(.CYCLES(FLUSH_CYCLES)) u_tx_flush (
      .clk(clk), .rst_n(rst_n), .start(wr_ctrl && reg_wdata[0]),
      .busy(tx_busy), .done(tx_done));

   tfq_flush_seq #(.CYCLES(FLUSH_CYCLES)) u_rx_flush (
      .clk(clk), .rst_n(rst_n), .start(wr_ctrl && reg_wdata[1]),
      .busy(rx_busy), .done(rx_done));

   tfq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .clear(tx_done),
      .push(tx_push), .din(reg_wdata[DW-1:0]), .pop(tx_pop),
      .dout(eng_tx_data), .count(tx_count), .empty(tx_empty), .full(tx_full));

   tfq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .clear(rx_done),
      .push(rx_push), .din(eng_rx_data), .pop(rx_pop),
      .dout(rx_dout), .count(rx_count), .empty(rx_empty), .full(rx_full));

   assign eng_tx_valid = !tx_empty && !tx_busy;
   assign eng_rx_ready = !rx_full && !rx_busy;

   always_comb begin
      level_vec              = '0;
      level_vec[B_TX_EMPTY]  = tx_empty;
      level_vec[B_TX_NEMPTY] = (tx_count <= CW'(tx_thr));
      level_vec[B_TX_FULL]   = tx_full;
      level_vec[B_RX_EMPTY]  = rx_empty;
      level_vec[B_RX_NFULL]  = (rx_count >= CW'(rx_thr));
      level_vec[B_RX_FULL]   = rx_full;
   end

   always_comb begin
      evt_vec              = '0;
      evt_vec[B_TX_OVR]    = tx_ovr;
      evt_vec[B_SLV0]      = evt_slave[0];
      evt_vec[B_SLV1]      = evt_slave[1];
      evt_vec[B_SLV2]      = evt_slave[2];
      evt_vec[B_SLV3]      = evt_slave[3];
      evt_vec[B_DONE_STOP] = evt_done_stop;
      evt_vec[B_DONE_NOST] = evt_done_nostop;
      evt_vec[B_ARB_LOST]  = evt_arb_lost;
      evt_vec[B_BUS_ERR]   = evt_bus_err;
   end

   tfq_irq_unit u_irq (
      .clk(clk), .rst_n(rst_n), .level(level_vec), .evt(evt_vec),
      .mask_we(reg_wr && (reg_addr == REG_MASK)),
      .clr_we(reg_wr && (reg_addr == REG_CLEAR)),
      .wdata(reg_wdata), .raw(raw_status), .masked(masked_status),
      .mask_q(mask_q), .irq(irq));

   always_comb begin
      case (reg_addr)
         REG_CTRL:   reg_rdata = {30'd0, rx_busy, tx_busy};
         REG_RXDATA: reg_rdata = rx_busy ? '0 : 32'(rx_dout);
         REG_TXTHR:  reg_rdata = 32'(tx_thr);
         REG_RXTHR:  reg_rdata = 32'(rx_thr);
         REG_MASK:   reg_rdata = mask_q;
         REG_RAW:    reg_rdata = raw_status;
         REG_MASKED: reg_rdata = masked_status;
         default:    reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tfq_chk.sv
module tfq_chk
   import tfq_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       reg_wr,
   input logic [3:0]                 reg_addr,
   input logic [31:0]                reg_wdata,
   input logic [31:0]                reg_rdata,
   input logic                       irq,
   input logic                       evt_bus_err,
   input logic                       evt_arb_lost,
   input logic                       tx_busy,
   input logic [$clog2(DEPTH+1)-1:0] tx_count,
   input logic [31:0]                raw_status
);
   localparam int CW = $clog2(DEPTH+1);

   p_mask_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == REG_MASK) |-> (reg_rdata[31:29] == 3'b000));

   p_irq_follows_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == REG_MASKED) |-> (irq == (reg_rdata != 32'd0)));

   p_overrun_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_TXDATA && tx_count == CW'(DEPTH) && !tx_busy)
      |=> raw_status[B_TX_OVR]);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CW'(DEPTH));

   p_flush_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> (tx_count == '0));

   p_bus_err_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_bus_err |=> raw_status[B_BUS_ERR]);

   p_w1c_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_CLEAR && reg_wdata[B_ARB_LOST] && !evt_arb_lost)
      |=> !raw_status[B_ARB_LOST]);

endmodule

bind txrx_fifo_irq tfq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
   .evt_bus_err(evt_bus_err), .evt_arb_lost(evt_arb_lost),
   .tx_busy(tx_busy), .tx_count(tx_count), .raw_status(raw_status));

// File: tb/txrx_fifo_irq_test.sv
module txrx_fifo_irq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        eng_tx_pop = 1'b0;
   logic [7:0]  eng_tx_data;
   logic        eng_tx_valid;
   logic        eng_rx_push = 1'b0;
   logic [7:0]  eng_rx_data = 8'd0;
   logic        eng_rx_ready;
   logic        evt_done_stop = 1'b0, evt_done_nostop = 1'b0;
   logic        evt_arb_lost = 1'b0, evt_bus_err = 1'b0;
   logic [3:0]  evt_slave = 4'd0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   txrx_fifo_irq uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
      .evt_done_stop(evt_done_stop), .evt_done_nostop(evt_done_nostop),
      .evt_arb_lost(evt_arb_lost), .evt_bus_err(evt_bus_err),
      .evt_slave(evt_slave), .irq(irq));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rx_push(input logic [7:0] d);
      eng_rx_data = d; eng_rx_push = 1'b1;
      @(negedge clk);
      eng_rx_push = 1'b0;
   endtask

   task automatic tx_take(input string req, input logic [7:0] exp);
      check(req, "tx valid", 32'(eng_tx_valid), 32'd1);
      check(req, "tx data order", 32'(eng_tx_data), 32'(exp));
      eng_tx_pop = 1'b1;
      @(negedge clk);
      eng_tx_pop = 1'b0;
   endtask

   task automatic pulse_evt(input int k, input logic with_clear);
      case (k)
         0: evt_done_stop = 1'b1;
         1: evt_done_nostop = 1'b1;
         2: evt_arb_lost = 1'b1;
         3: evt_bus_err = 1'b1;
         default: evt_slave[k-4] = 1'b1;
      endcase
      if (with_clear) begin
         reg_addr = 4'd8; reg_wdata = 32'h131F_007F; reg_wr = 1'b1;
      end
      @(negedge clk);
      reg_wr = 1'b0;
      evt_done_stop = 1'b0; evt_done_nostop = 1'b0;
      evt_arb_lost = 1'b0; evt_bus_err = 1'b0; evt_slave = 4'd0;
   endtask

   function automatic int evt_pos(input int k);
      case (k)
         0: return 19;
         1: return 28;
         2: return 24;
         3: return 25;
         4: return 16;
         5: return 17;
         6: return 18;
         default: return 20;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(4'd6, d); check("R1", "raw after reset", d, 32'h0000_0033);
      rd(4'd5, d); check("R1", "mask after reset", d, 32'd0);
      rd(4'd0, d); check("R1", "control after reset", d, 32'd0);
      rd(4'd3, d); check("R1", "tx threshold after reset", d, 32'd0);
      check("R1", "irq after reset", 32'(irq), 32'd0);
      rd(4'd9, d); check("R2", "unmapped address", d, 32'd0);

      // R3 R5 R6 R8: transmit sweep over thresholds and fill levels
      foreach (d[i]) begin end
      for (int t = 0; t < 4; t++) begin
         int thr;
         thr = (t == 0) ? 0 : (t == 1) ? 3 : (t == 2) ? 7 : 15;
         wr(4'd3, 32'hFFFF_FFF0 | 32'(thr));
         rd(4'd3, d); check("R6", "threshold keeps 4 bits", d, 32'(thr));
         for (int n = 0; n <= 16; n++) begin
            rd(4'd6, d);
            check("R5", "tx empty bit", 32'(d[0]), 32'(n == 0));
            check("R6", "tx nearly empty bit", 32'(d[1]), 32'(n <= thr));
            check("R5", "tx full bit", 32'(d[2]), 32'(n == 16));
            if (n < 16) wr(4'd1, 32'((n * 7 + thr) & 8'hFF));
         end
         check("R8", "overrun clear before", 32'(d[3]), 32'd0);
         wr(4'd1, 32'h0000_00EE);
         rd(4'd6, d);
         check("R8", "overrun latched", 32'(d[3]), 32'd1);
         check("R8", "still full", 32'(d[2]), 32'd1);
         for (int n = 0; n < 16; n++)
            tx_take("R3", 8'((n * 7 + thr) & 8'hFF));
         check("R3", "tx drained", 32'(eng_tx_valid), 32'd0);
         wr(4'd8, 32'h0000_0008);
         rd(4'd6, d); check("R10", "overrun cleared", 32'(d[3]), 32'd0);
      end

      // R4 R5 R7: receive sweep
      for (int t = 0; t < 4; t++) begin
         int thr;
         thr = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 8 : 15;
         wr(4'd4, 32'(thr));
         for (int n = 0; n <= 16; n++) begin
            rd(4'd6, d);
            check("R5", "rx empty bit", 32'(d[4]), 32'(n == 0));
            check("R7", "rx nearly full bit", 32'(d[5]), 32'(n >= thr));
            check("R5", "rx full bit", 32'(d[6]), 32'(n == 16));
            check("R4", "rx ready", 32'(eng_rx_ready), 32'(n < 16));
            if (n < 16) rx_push(8'(8'hA0 ^ n ^ (thr << 4)));
         end
         rx_push(8'h5A);
         for (int n = 0; n < 16; n++) begin
            rd(4'd2, d);
            check("R4", "rx data order", d, 32'(8'(8'hA0 ^ n ^ (thr << 4))));
         end
         rd(4'd2, d); check("R4", "empty read returns 0", d, 32'd0);
         rd(4'd6, d); check("R4", "still empty after empty read", 32'(d[4]), 32'd1);
         rx_push(8'h3C);
         rd(4'd2, d); check("R4", "pointer unchanged by empty read", d, 32'h3C);
      end

      // R9 R10 R11: transaction events
      wr(4'd4, 32'd0);
      wr(4'd3, 32'd0);
      for (int k = 0; k < 8; k++) begin
         int p;
         p = evt_pos(k);
         pulse_evt(k, 1'b0);
         rd(4'd6, d);
         check("R9", $sformatf("event bit %0d set", p), d, 32'h33 | (32'd1 << p));
         check("R11", "irq off with mask 0", 32'(irq), 32'd0);
         wr(4'd5, 32'd1 << p);
         rd(4'd7, d);
         check("R11", "masked status", d, 32'd1 << p);
         check("R11", "irq on", 32'(irq), 32'd1);
         wr(4'd8, 32'hFFFF_FFFF);
         rd(4'd6, d);
         check("R10", $sformatf("bit %0d cleared, level kept", p), d, 32'h33);
         check("R11", "irq off after clear", 32'(irq), 32'd0);
         pulse_evt(k, 1'b1);
         rd(4'd6, d);
         check("R10", "set wins over clear", 32'(d[p]), 32'd1);
         wr(4'd8, 32'd1 << p);
         wr(4'd5, 32'd0);
      end
      wr(4'd5, 32'hFFFF_FFFF);
      rd(4'd5, d); check("R11", "mask reserved bits", d, 32'h1FFF_FFFF);
      rd(4'd7, d); check("R11", "masked level bits", d, 32'h33);
      check("R11", "irq from level bits", 32'(irq), 32'd1);
      wr(4'd5, 32'd0);

      // R12 R13: transmit flush
      wr(4'd1, 32'h11); wr(4'd1, 32'h22); wr(4'd1, 32'h33);
      wr(4'd0, 32'h1);
      for (int c = 0; c < 5; c++) begin
         rd(4'd0, d);
         check("R12", $sformatf("tx flush bit cycle %0d", c), d, (c < 4) ? 32'h1 : 32'h0);
      end
      rd(4'd6, d); check("R12", "tx empty after flush", 32'(d[0]), 32'd1);
      wr(4'd0, 32'h1);
      wr(4'd1, 32'h55);
      check("R13", "tx not valid during flush", 32'(eng_tx_valid), 32'd0);
      eng_tx_pop = 1'b1; idle(1); eng_tx_pop = 1'b0;
      idle(3);
      rd(4'd6, d); check("R13", "write during flush ignored", 32'(d[0]), 32'd1);
      wr(4'd1, 32'h66);
      tx_take("R13", 8'h66);

      // R12 R13: receive flush
      rx_push(8'h01); rx_push(8'h02);
      wr(4'd0, 32'h2);
      rd(4'd0, d); check("R12", "rx flush bit", d, 32'h2);
      rd(4'd2, d); check("R13", "rx read during flush is 0", d, 32'd0);
      rx_push(8'h77);
      idle(2);
      rd(4'd0, d); check("R12", "rx flush bit self-clears", d, 32'h0);
      rd(4'd6, d); check("R13", "rx empty after flush", 32'(d[4]), 32'd1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      done = 1;
      $finish;
   end

endmodule